// File: doc/BRIEF.md
# Chained Device Descriptor Table Walker

The walker scans a table of 32-bit descriptor words, one index at a time, through a synchronous read port with a fixed latency of one cycle. Consecutive words are grouped into one device by a continuation flag in bit 31. Each word is decoded according to the type code in bits 1:0. Decoded fields are merged into a running device record. When the word that closes a device has been handled, the record goes out on a valid/ready interface. It carries the engine, queue, interrupt and reset ids, the instance id, the device register base address, the fault id and the engine type code. Each optional field comes with its own valid flag.

A one-cycle `start_i` pulse begins a walk from index 0. After the last index has been handled, and after any record it produced has been accepted, `done_o` pulses for one cycle. Every device needs a register base. A record that closes without a data word, or that is cut off at the end of the table, is flagged with `rec_err_o`. Back-pressure on the record output pauses the walk, and no table word is lost.

Top module: `dev_desc_walker`

## Requirements
- R1: After `start_i`, the block reads each index from 0 to NUM_ENTRIES-1 exactly once, in ascending order, at address TABLE_BASE + 4*index. Reads are never issued on back-to-back cycles. `done_o` is a single-cycle pulse that follows the handling of the last index.
- R2: Bit 31 of a word is the continuation flag, where 1 means the next word belongs to the same device. Bits 1:0 give the type: 0 skip, 1 data, 2 enumeration, 3 engine type.
- R3: An enumeration word supplies the engine id in bits 29:26 (valid flag bit 5), the queue id in bits 24:21 (flag bit 4), the interrupt id in bits 19:15 (flag bit 3) and the reset id in bits 13:9 (flag bit 2).
- R4: A data word supplies the instance id in bits 29:26, the register base field in bits 23:12 and the fault id in bits 9:3 (flag bit 2). The reported base address is the field shifted left by 12. A data word with bit 30 set has an undefined subtype and is treated as a skip word.
- R5: An engine-type word supplies a 29-bit engine type code from bits 30:2, and sets the type valid flag.
- R6: Every field whose valid flag is clear is reported as 0. The instance id and base are 0 when the record holds no data word.
- R7: A record is emitted after a word with bit 31 clear is handled, but only if the chain contains at least one non-skip word. Skip words with bit 31 set do not end a chain. A chain made only of skip words produces no record.
- R8: `rec_err_o` is set on a record that contains no data word.
- R9: If a chain with at least one non-skip word is still open after the last index, it is emitted with `rec_err_o` set.
- R10: While `rec_valid_o` is high and `rec_ready_i` is low, all record outputs stay stable and no read is issued.
- R11: Out of reset, `rd_en_o`, `rec_valid_o` and `done_o` are low. A `start_i` pulse during a walk is ignored.
- R12: Within a chain, a later word of the same type replaces every field that an earlier word of that type supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (pulse) |
| done_o | output | 1 | Walk finished (one-cycle pulse) |
| rd_en_o | output | 1 | Table read request |
| rd_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_data_i | input | 32 | Word returned one cycle after the request |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Record accepted |
| rec_engine_o | output | 4 | Engine id |
| rec_engine_vld_o | output | 1 | Engine id valid |
| rec_queue_o | output | 4 | Queue id |
| rec_queue_vld_o | output | 1 | Queue id valid |
| rec_intr_o | output | 5 | Interrupt id |
| rec_intr_vld_o | output | 1 | Interrupt id valid |
| rec_reset_o | output | 5 | Reset id |
| rec_reset_vld_o | output | 1 | Reset id valid |
| rec_inst_o | output | 4 | Instance id |
| rec_base_o | output | 32 | Device register base address |
| rec_fault_o | output | 7 | Fault id |
| rec_fault_vld_o | output | 1 | Fault id valid |
| rec_type_o | output | 29 | Engine type code |
| rec_type_vld_o | output | 1 | Engine type valid |
| rec_err_o | output | 1 | Missing data word or truncated chain |

## Verification
A hand-built table places chains of every shape side by side:
- a full three-word device;
- a data-only device and a type-only device;
- enumeration words with cleared flags over non-zero fields;
- skip words inside chains and skip-only chains;
- a repeated enumeration word;
- a data word with the undefined subtype;
- a chain left open at the last index.

These cases tell closing apart from skipping, and zero-gating apart from plain extraction. The same table is then walked under random back-pressure, which separates record holding from record loss. About thirty pseudo-random tables follow, together with an all-skip table. Each walk includes a stray start pulse partway through, and each read address is compared against a strictly ascending index.

// File: rtl/dev_desc_pkg.sv
`timescale 1ns/1ps
package dev_desc_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ENT_SKIP = 2'd0,
    ENT_DATA = 2'd1,
    ENT_ENUM = 2'd2,
    ENT_KIND = 2'd3
  } ent_kind_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_REQ,
    W_DATA,
    W_OUT,
    W_FIN
  } walk_st_e;

  typedef struct packed {
    logic [3:0]  engine;
    logic        engine_vld;
    logic [3:0]  queue;
    logic        queue_vld;
    logic [4:0]  intr;
    logic        intr_vld;
    logic [4:0]  rst;
    logic        rst_vld;
    logic [3:0]  inst;
    logic [11:0] base_fld;
    logic        has_data;
    logic [6:0]  fault;
    logic        fault_vld;
    logic [28:0] kind;
    logic        kind_vld;
  } dev_rec_t;
endpackage

// File: rtl/dev_desc_word_dec.sv
`timescale 1ns/1ps
module dev_desc_word_dec
  import dev_desc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              cont_o,
  output logic              act_o,
  output logic              en_enum_o,
  output logic              en_data_o,
  output logic              en_kind_o,
  output dev_rec_t          fld_o
);
  ent_kind_e kind;
  logic      unused_w;

  assign unused_w = ^{word_i[25], word_i[20], word_i[14], word_i[11:10], word_i[8:6]};

  always_comb begin
    kind      = ent_kind_e'(word_i[1:0]);
    cont_o    = word_i[31];
    en_enum_o = (kind == ENT_ENUM);
    // only data subtype 0 is defined
    en_data_o = (kind == ENT_DATA) && !word_i[30];
    en_kind_o = (kind == ENT_KIND);
    act_o     = en_enum_o | en_data_o | en_kind_o;

    fld_o            = '0;
    fld_o.engine_vld = word_i[5];
    fld_o.engine     = word_i[5] ? word_i[29:26] : '0;
    fld_o.queue_vld  = word_i[4];
    fld_o.queue      = word_i[4] ? word_i[24:21] : '0;
    fld_o.intr_vld   = word_i[3];
    fld_o.intr       = word_i[3] ? word_i[19:15] : '0;
    fld_o.rst_vld    = word_i[2];
    fld_o.rst        = word_i[2] ? word_i[13:9] : '0;
    fld_o.inst       = word_i[29:26];
    fld_o.base_fld   = word_i[23:12];
    fld_o.has_data   = 1'b1;
    fld_o.fault_vld  = word_i[2];
    fld_o.fault      = word_i[2] ? word_i[9:3] : '0;
    fld_o.kind       = word_i[30:2];
    fld_o.kind_vld   = 1'b1;
  end
endmodule

// File: rtl/dev_desc_rec_acc.sv
`timescale 1ns/1ps
module dev_desc_rec_acc
  import dev_desc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     upd_i,
  input  logic     en_enum_i,
  input  logic     en_data_i,
  input  logic     en_kind_i,
  input  dev_rec_t fld_i,
  output dev_rec_t rec_o,
  output logic     seen_o
);
  dev_rec_t rec_q;
  logic     seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      rec_q  <= '0;
      seen_q <= 1'b0;
    end else if (upd_i) begin
      seen_q <= 1'b1;
      if (en_enum_i) begin
        rec_q.engine     <= fld_i.engine;
        rec_q.engine_vld <= fld_i.engine_vld;
        rec_q.queue      <= fld_i.queue;
        rec_q.queue_vld  <= fld_i.queue_vld;
        rec_q.intr       <= fld_i.intr;
        rec_q.intr_vld   <= fld_i.intr_vld;
        rec_q.rst        <= fld_i.rst;
        rec_q.rst_vld    <= fld_i.rst_vld;
      end
      if (en_data_i) begin
        rec_q.inst      <= fld_i.inst;
        rec_q.base_fld  <= fld_i.base_fld;
        rec_q.has_data  <= fld_i.has_data;
        rec_q.fault     <= fld_i.fault;
        rec_q.fault_vld <= fld_i.fault_vld;
      end
      if (en_kind_i) begin
        rec_q.kind     <= fld_i.kind;
        rec_q.kind_vld <= fld_i.kind_vld;
      end
    end
  end

  assign rec_o  = rec_q;
  assign seen_o = seen_q;
endmodule

// File: rtl/dev_desc_walk_ctrl.sv
`timescale 1ns/1ps
module dev_desc_walk_ctrl
  import dev_desc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             act_i,
  input  logic             cont_i,
  input  logic             seen_i,
  input  logic             rec_ready_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             clr_o,
  output logic             upd_o,
  output logic             rec_valid_o,
  output logic             trunc_o,
  output logic             done_o
);
  walk_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             trunc_q, trunc_d;
  logic             last, open_chain;

  assign last       = (idx_q == IDX_W'(NUM_ENTRIES - 1));
  assign open_chain = seen_i | act_i;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    trunc_d = trunc_q;
    clr_o   = 1'b0;
    upd_o   = 1'b0;
    unique case (st_q)
      W_IDLE: if (start_i) begin
        idx_d   = '0;
        trunc_d = 1'b0;
        clr_o   = 1'b1;
        st_d    = W_REQ;
      end
      W_REQ: st_d = W_DATA;
      W_DATA: begin
        upd_o = act_i;
        if (!cont_i && open_chain) begin
          st_d = W_OUT;
        end else if (last) begin
          if (open_chain) begin
            trunc_d = 1'b1;
            st_d    = W_OUT;
          end else begin
            st_d = W_FIN;
          end
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = W_REQ;
        end
      end
      W_OUT: if (rec_ready_i) begin
        clr_o   = 1'b1;
        trunc_d = 1'b0;
        if (last) begin
          st_d = W_FIN;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = W_REQ;
        end
      end
      W_FIN: st_d = W_IDLE;
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      idx_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      trunc_q <= trunc_d;
    end
  end

  assign rd_en_o     = (st_q == W_REQ);
  assign rec_valid_o = (st_q == W_OUT);
  assign done_o      = (st_q == W_FIN);
  assign idx_o       = idx_q;
  assign trunc_o     = trunc_q;
endmodule

// File: rtl/dev_desc_walker.sv
`timescale 1ns/1ps
module dev_desc_walker
  import dev_desc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [3:0]        rec_engine_o,
  output logic              rec_engine_vld_o,
  output logic [3:0]        rec_queue_o,
  output logic              rec_queue_vld_o,
  output logic [4:0]        rec_intr_o,
  output logic              rec_intr_vld_o,
  output logic [4:0]        rec_reset_o,
  output logic              rec_reset_vld_o,
  output logic [3:0]        rec_inst_o,
  output logic [31:0]       rec_base_o,
  output logic [6:0]        rec_fault_o,
  output logic              rec_fault_vld_o,
  output logic [28:0]       rec_type_o,
  output logic              rec_type_vld_o,
  output logic              rec_err_o
);
  logic             cont, act, en_enum, en_data, en_kind;
  logic             seen, clr, upd, trunc;
  logic [IDX_W-1:0] idx;
  dev_rec_t         fld, rec;

  dev_desc_word_dec u_dec (
    .word_i    (rd_data_i),
    .cont_o    (cont),
    .act_o     (act),
    .en_enum_o (en_enum),
    .en_data_o (en_data),
    .en_kind_o (en_kind),
    .fld_o     (fld)
  );

  dev_desc_rec_acc u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .upd_i     (upd),
    .en_enum_i (en_enum),
    .en_data_i (en_data),
    .en_kind_i (en_kind),
    .fld_i     (fld),
    .rec_o     (rec),
    .seen_o    (seen)
  );

  dev_desc_walk_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .act_i       (act),
    .cont_i      (cont),
    .seen_i      (seen),
    .rec_ready_i (rec_ready_i),
    .rd_en_o     (rd_en_o),
    .idx_o       (idx),
    .clr_o       (clr),
    .upd_o       (upd),
    .rec_valid_o (rec_valid_o),
    .trunc_o     (trunc),
    .done_o      (done_o)
  );

  assign rd_addr_o        = TABLE_BASE + (ADDR_W'(idx) << 2);
  assign rec_engine_o     = rec.engine;
  assign rec_engine_vld_o = rec.engine_vld;
  assign rec_queue_o      = rec.queue;
  assign rec_queue_vld_o  = rec.queue_vld;
  assign rec_intr_o       = rec.intr;
  assign rec_intr_vld_o   = rec.intr_vld;
  assign rec_reset_o      = rec.rst;
  assign rec_reset_vld_o  = rec.rst_vld;
  assign rec_inst_o       = rec.inst;
  assign rec_base_o       = {8'b0, rec.base_fld, 12'b0};
  assign rec_fault_o      = rec.fault;
  assign rec_fault_vld_o  = rec.fault_vld;
  assign rec_type_o       = rec.kind;
  assign rec_type_vld_o   = rec.kind_vld;
  assign rec_err_o        = !rec.has_data || trunc;
endmodule

// File: rtl/dev_desc_walker_chk.sv
`timescale 1ns/1ps
module dev_desc_walker_chk #(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] TABLE_BASE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [3:0]        rec_engine_o,
  input logic              rec_engine_vld_o,
  input logic [3:0]        rec_queue_o,
  input logic              rec_queue_vld_o,
  input logic [4:0]        rec_intr_o,
  input logic              rec_intr_vld_o,
  input logic [4:0]        rec_reset_o,
  input logic              rec_reset_vld_o,
  input logic [3:0]        rec_inst_o,
  input logic [31:0]       rec_base_o,
  input logic [6:0]        rec_fault_o,
  input logic              rec_fault_vld_o,
  input logic [28:0]       rec_type_o,
  input logic              rec_type_vld_o,
  input logic              rec_err_o
);
  logic [ADDR_W-1:0] off;
  assign off = rd_addr_o - TABLE_BASE;

  AST_READ_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o); // R1
  AST_ADDR_IN_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (off[1:0] == 2'b00) && (off < ADDR_W'(4 * NUM_ENTRIES))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rec_valid_o && !rd_en_o); // R1
  AST_NO_READ_WHILE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !rd_en_o); // R10
  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable({rec_engine_o, rec_engine_vld_o,
      rec_queue_o, rec_queue_vld_o, rec_intr_o, rec_intr_vld_o, rec_reset_o, rec_reset_vld_o,
      rec_inst_o, rec_base_o, rec_fault_o, rec_fault_vld_o, rec_type_o, rec_type_vld_o,
      rec_err_o})); // R10
  AST_ENGINE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_engine_vld_o |-> rec_engine_o == '0); // R6
  AST_QUEUE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_queue_vld_o |-> rec_queue_o == '0); // R6
  AST_INTR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_intr_vld_o |-> rec_intr_o == '0); // R6
  AST_RESET_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_reset_vld_o |-> rec_reset_o == '0); // R6
  AST_FAULT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_fault_vld_o |-> rec_fault_o == '0); // R6
  AST_TYPE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_type_vld_o |-> rec_type_o == '0); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_base_o[11:0] == 12'h000 && rec_base_o[31:24] == 8'h00); // R4
endmodule

bind dev_desc_walker dev_desc_walker_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
  .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
  .rec_engine_o(rec_engine_o), .rec_engine_vld_o(rec_engine_vld_o),
  .rec_queue_o(rec_queue_o), .rec_queue_vld_o(rec_queue_vld_o),
  .rec_intr_o(rec_intr_o), .rec_intr_vld_o(rec_intr_vld_o),
  .rec_reset_o(rec_reset_o), .rec_reset_vld_o(rec_reset_vld_o),
  .rec_inst_o(rec_inst_o), .rec_base_o(rec_base_o),
  .rec_fault_o(rec_fault_o), .rec_fault_vld_o(rec_fault_vld_o),
  .rec_type_o(rec_type_o), .rec_type_vld_o(rec_type_vld_o), .rec_err_o(rec_err_o)
);

// File: tb/dev_desc_walker_tb_top.sv
`timescale 1ns/1ps
module dev_desc_walker_tb_top;
  localparam int unsigned N = 64;
  localparam logic [31:0] TB_BASE = 32'h0004_1000;
  localparam int unsigned VW = 97;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0, rdy = 1'b0;
  logic done, rd_en, rec_valid;
  logic [31:0] rd_addr, rd_data = '0;
  logic [3:0] engine, queue, inst;
  logic [4:0] intr, rst_id;
  logic [31:0] base;
  logic [6:0] fault;
  logic [28:0] kcode;
  logic ev, qv, iv, rv, fv, kv, err;

  dev_desc_walker #(.NUM_ENTRIES(N), .ADDR_W(32), .TABLE_BASE(TB_BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done), .rd_en_o(rd_en),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rec_valid_o(rec_valid), .rec_ready_i(rdy),
    .rec_engine_o(engine), .rec_engine_vld_o(ev), .rec_queue_o(queue), .rec_queue_vld_o(qv),
    .rec_intr_o(intr), .rec_intr_vld_o(iv), .rec_reset_o(rst_id), .rec_reset_vld_o(rv),
    .rec_inst_o(inst), .rec_base_o(base), .rec_fault_o(fault), .rec_fault_vld_o(fv),
    .rec_type_o(kcode), .rec_type_vld_o(kv), .rec_err_o(err)
  );

  logic [31:0]   mem [N];
  logic [VW-1:0] exp_rec [N];
  int exp_cnt, got_cnt, rd_cnt, n_chk = 0, n_fail = 0, bp_mode = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [VW-1:0] act_vec, hold_vec;
  logic hold_pend = 1'b0;

  assign act_vec = {engine, ev, queue, qv, intr, iv, rst_id, rv, inst, base, fault, fv, kcode, kv, err};

  always @(posedge clk) if (rd_en) rd_data <= mem[6'((rd_addr - TB_BASE) >> 2)];

  task automatic chk(input bit ok, input string what, input logic [VW-1:0] a, input logic [VW-1:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, a, e);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // word builders
  function automatic logic [31:0] w_enum(bit c, logic [3:0] e, bit evb, logic [3:0] q, bit qvb,
                                         logic [4:0] it, bit ivb, logic [4:0] rs, bit rvb);
    return {c, 1'b0, e, 1'b0, q, 1'b0, it, 1'b0, rs, 3'b101, evb, qvb, ivb, rvb, 2'b10};
  endfunction
  function automatic logic [31:0] w_data(bit c, bit sub, logic [3:0] ins, logic [11:0] b,
                                         logic [6:0] f, bit fvb);
    return {c, sub, ins, 2'b11, b, 2'b10, f, fvb, 2'b01};
  endfunction
  function automatic logic [31:0] w_kind(bit c, logic [28:0] k);
    return {c, k, 2'b11};
  endfunction
  function automatic logic [31:0] w_skip(bit c, logic [28:0] junk);
    return {c, junk, 2'b00};
  endfunction

  // expected records, computed from R2-R9/R12 with shift and mask arithmetic
  task automatic build_expect();
    logic [3:0] e, q, ins; logic [4:0] it, rs; logic [31:0] b; logic [6:0] f; logic [28:0] k;
    logic evb, qvb, ivb, rvb, fvb, kvb, hd, sn;
    e = 0; q = 0; ins = 0; it = 0; rs = 0; b = 0; f = 0; k = 0;
    evb = 0; qvb = 0; ivb = 0; rvb = 0; fvb = 0; kvb = 0; hd = 0; sn = 0;
    exp_cnt = 0;
    for (int i = 0; i < int'(N); i++) begin
      logic [31:0] w; int t; bit a, emit, bad;
      w = mem[i]; t = int'(w % 4);
      a = (t == 2) || (t == 3) || (t == 1 && (w / 32'h4000_0000) % 2 == 0);
      if (a && t == 2) begin
        evb = w[5]; qvb = w[4]; ivb = w[3]; rvb = w[2];
        e  = evb ? 4'((w >> 26) & 32'hF)  : 4'd0;
        q  = qvb ? 4'((w >> 21) & 32'hF)  : 4'd0;
        it = ivb ? 5'((w >> 15) & 32'h1F) : 5'd0;
        rs = rvb ? 5'((w >> 9) & 32'h1F)  : 5'd0;
      end
      if (a && t == 1) begin
        hd = 1; ins = 4'((w >> 26) & 32'hF); b = w & 32'h00FF_F000;
        fvb = w[2]; f = fvb ? 7'((w >> 3) & 32'h7F) : 7'd0;
      end
      if (a && t == 3) begin kvb = 1; k = 29'(w >> 2); end
      sn = sn | a;
      emit = 0; bad = 0;
      if (!w[31] && sn) begin emit = 1; bad = !hd; end
      else if (i == int'(N) - 1 && sn) begin emit = 1; bad = 1; end
      if (emit) begin
        exp_rec[exp_cnt] = {e, evb, q, qvb, it, ivb, rs, rvb, ins, b, f, fvb, k, kvb, bad};
        exp_cnt++;
        e = 0; q = 0; ins = 0; it = 0; rs = 0; b = 0; f = 0; k = 0;
        evb = 0; qvb = 0; ivb = 0; rvb = 0; fvb = 0; kvb = 0; hd = 0; sn = 0;
      end
    end
  endtask

  // monitor: drive ready, then check handshake, hold and read order
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(rec_valid && act_vec == hold_vec, "R10 record held under back-pressure", act_vec, hold_vec);
      lcg = nxt(lcg);
      rdy = (bp_mode == 0) ? 1'b1 : lcg[17] & lcg[23];
      if (rec_valid && rdy) begin
        if (got_cnt < exp_cnt)
          chk(act_vec == exp_rec[got_cnt], $sformatf("R3/R4/R5/R6/R8/R9/R12 record %0d", got_cnt),
              act_vec, exp_rec[got_cnt]);
        else
          chk(1'b0, "R7 unexpected record", act_vec, '0);
        got_cnt++;
      end
      hold_pend = rec_valid && !rdy;
      hold_vec  = act_vec;
      if (rd_en) begin
        chk(rd_addr == TB_BASE + 32'(rd_cnt) * 4, "R1 read address order",
            VW'(rd_addr), VW'(TB_BASE + 32'(rd_cnt) * 4));
        rd_cnt++;
      end
    end
  end

  task automatic run_walk(input int bp, input string name);
    bit seen_done;
    build_expect();
    got_cnt = 0; rd_cnt = 0; bp_mode = bp; seen_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c == 20) start = 1'b1;  // stray start, R11
      if (c == 21) start = 1'b0;
      #1;
      if (done) begin seen_done = 1; break; end
    end
    if (!seen_done) begin
      chk(1'b0, {"watchdog expired in walk ", name}, '0, '0);
    end else begin
      chk(rd_cnt == int'(N), {"R1 read count ", name}, VW'(rd_cnt), VW'(N));
      chk(got_cnt == exp_cnt, {"R7 record count ", name}, VW'(got_cnt), VW'(exp_cnt));
      @(negedge clk); #1;
      chk(!done && !rec_valid && !rd_en, "R1 done single pulse, walk idle", VW'({done, rec_valid, rd_en}), '0);
    end
  endtask

  initial begin
    for (int i = 0; i < int'(N); i++) mem[i] = '0;
    #1;
    chk(!rd_en && !rec_valid && !done, "R11 reset state", VW'({rd_en, rec_valid, done}), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!rd_en && !rec_valid && !done, "R11 idle after reset", VW'({rd_en, rec_valid, done}), '0);

    // hand-built table covering R2-R9, R12
    mem[0]  = w_enum(1, 4'd3, 1, 4'd5, 1, 5'd17, 1, 5'd9, 1);
    mem[1]  = w_data(1, 0, 4'd2, 12'hABC, 7'h55, 1);
    mem[2]  = w_kind(0, 29'd19);
    mem[3]  = w_data(0, 0, 4'd1, 12'h123, 7'h07, 0);
    mem[4]  = w_kind(0, 29'h1FFF_FFFF);
    mem[5]  = w_skip(1, 29'h0ABC_DEF1);
    mem[6]  = w_enum(1, 4'hF, 0, 4'hF, 0, 5'h1F, 0, 5'h1F, 0);
    mem[7]  = w_skip(1, 29'h1555_5555);
    mem[8]  = w_data(0, 0, 4'hF, 12'hFFF, 7'h7F, 1);
    mem[9]  = w_skip(0, 29'h1);
    mem[10] = w_skip(1, 29'h2);
    mem[11] = w_skip(0, 29'h3);
    mem[12] = w_enum(1, 4'd1, 1, 4'd1, 1, 5'd1, 1, 5'd1, 1);
    mem[13] = w_enum(1, 4'd9, 1, 4'd0, 0, 5'd4, 1, 5'd0, 0);
    mem[14] = w_data(1, 1, 4'd7, 12'h777, 7'h11, 1);
    mem[15] = w_data(1, 0, 4'd0, 12'h001, 7'h00, 0);
    mem[16] = w_skip(0, 29'h0);
    mem[17] = w_data(0, 1, 4'd3, 12'h333, 7'h22, 1);
    mem[62] = w_kind(1, 29'd5);
    mem[63] = w_enum(1, 4'd2, 1, 4'd3, 1, 5'd4, 1, 5'd5, 1);
    run_walk(0, "directed");
    run_walk(1, "directed back-pressure");

    for (int i = 0; i < int'(N); i++) mem[i] = '0;
    run_walk(1, "all skip");

    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < int'(N); i++) begin
        lcg = nxt(lcg);
        mem[i] = lcg ^ (lcg << 7);
      end
      run_walk(t % 2, $sformatf("random %0d", t));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule